// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This unit holds the replacement state of a set-associative cache. Each set keeps a binary decision tree of `WAYS-1` bits, stored heap-style: node 0 is the root, and node `i` has children `2i+1` and `2i+2`. The cache controller uses two ports. When a way has been touched, it presents the set index and the way on the update port. When it needs to refill a line, it presents a set index on the victim port and reads back the way to evict. A clear input returns every tree to zero.

The update port is a valid/ready stream. A transfer happens on a rising clock edge where `upd_valid` and `upd_ready` are both high. `upd_ready` is low only while `clear_all` is high, because clear wins over update. A producer that sees `upd_ready` low must hold its item and present it again later. The victim port is a plain combinational lookup with no handshake. `clear_all` is a plain control pin.

When `WAYS` is 1 there is no tree. Updates have no effect, and the victim is always way 0.

Top module: `plru_replacer`

## Requirements
- R1: After reset, the victim of every set is way 0, because all tree bits are zero.
- R2: An update of way `w` writes only the nodes on the path from the root to `w`'s leaf. The node at depth `d` (the root is depth 0, with `L = log2(WAYS)` levels) receives the complement of bit `L-1-d` of `w`. In heap terms: the leaf at base `(WAYS-1)/2 + w/2` stores 1 for an even `w`, and each parent stores 1 when the path came from its odd-numbered child.
- R3: The victim walk starts at the root. At a node holding 0 it moves to child `2i+1`, and at a node holding 1 it moves to child `2i+2`. The bit read at depth `d` becomes bit `L-1-d` of `vic_way`.
- R4: An update changes only the tree of `upd_set`. The victims of all other sets are unchanged.
- R5: `clear_all` zeroes the tree of every set on the next edge. While it is high, `upd_ready` is low, and an update presented in the same cycle is dropped.
- R6: `vic_way` depends combinationally on `vic_set` and the stored state. An accepted update becomes visible on `vic_way` only after the clock edge that accepts it.
- R7: With `WAYS` = 1, `vic_way` is always 0 whatever the updates are.
- R8: With `WAYS` > 1, directly after an accepted update of way `w` in set `s`, the victim of set `s` is not `w`.
- R9: For 4 ways starting from zero, using ways 0, 1, 2 and 3 in turn gives victims 2, 2, 0 and 0. After that, using 0 and then 2 gives victim 1. Using 1 then gives victim 3, and using 3 then gives victim 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; zeroes all trees |
| clear_all | input | 1 | Zero every tree on the next edge; has priority over update |
| upd_valid | input | 1 | An update item is present |
| upd_ready | output | 1 | The unit accepts an update this cycle (low during clear) |
| upd_set | input | SET_W | Set index of the update |
| upd_way | input | WAY_W | Way that was just used |
| vic_set | input | SET_W | Set index for the victim lookup |
| vic_way | output | WAY_W | Way to replace in `vic_set` |

## Verification
The bench drives the 4-way sequence that visits every leaf orientation. A unit that swapped the leaf polarity or the child-parity rule would return way 0 or 3 where 2 or 1 is expected. It checks that an update is not visible in the cycle it is presented, which catches a write-through read, and that other sets keep their victims, which catches a decode that writes every set. It also presents an update together with clear: a unit that let the update through would give a non-zero victim after the clear. A separate single-way instance checks the degenerate case, where any leaked tree logic would give a non-zero victim.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Operation applied to the tree storage on a clock edge.
  typedef enum logic [1:0] {
    TREE_HOLD  = 2'd0,
    TREE_WRITE = 2'd1,
    TREE_CLEAR = 2'd2
  } tree_op_e;

  // Number of tree levels for a power-of-two way count.
  function automatic int tree_levels(input int ways);
    int lv;
    lv = 0;
    while ((1 << lv) < ways) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/plru_path_update.sv
// Rewrites the nodes on the root-to-leaf path of one way.
module plru_path_update #(
  parameter int LEVELS = 2,
  parameter int WAY_W  = 2,
  parameter int TREE_W = 3
) (
  input  logic [TREE_W-1:0] old_tree,
  input  logic [WAY_W-1:0]  way,
  output logic [TREE_W-1:0] new_tree
);
  localparam int NODE_W = (TREE_W > 1) ? $clog2(TREE_W) : 1;

  always_comb begin
    new_tree = old_tree;
    for (int d = 0; d < LEVELS; d++) begin
      int node;
      int wbit;
      // node on the path at depth d: first index of the level plus prefix of way
      node = ((1 << d) - 1) + (int'(way) >> (LEVELS - d));
      wbit = (int'(way) >> (LEVELS - 1 - d)) & 1;
      new_tree[NODE_W'(node)] = (wbit == 0);
    end
  end
endmodule

// File: rtl/plru_victim_walk.sv
// Walks the tree from the root; each bit read is one bit of the victim.
module plru_victim_walk #(
  parameter int LEVELS = 2,
  parameter int WAY_W  = 2,
  parameter int TREE_W = 3
) (
  input  logic [TREE_W-1:0] tree,
  output logic [WAY_W-1:0]  victim
);
  localparam int NODE_W = (TREE_W > 1) ? $clog2(TREE_W) : 1;

  always_comb begin
    int node;
    logic b;
    victim = '0;
    node = 0;
    for (int d = 0; d < LEVELS; d++) begin
      b = tree[NODE_W'(node)];
      victim[WAY_W'(LEVELS - 1 - d)] = b;
      node = 2 * node + 1 + int'(b);
      if (node >= TREE_W) node = 0;
    end
  end
endmodule

// File: rtl/plru_tree_store.sv
// Per-set tree registers: one write port, one read for update, one for victim.
module plru_tree_store
  import plru_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int SET_W  = 4,
  parameter int TREE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tree_op_e          op,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TREE_W-1:0] wr_tree,
  input  logic [SET_W-1:0]  upd_rd_set,
  output logic [TREE_W-1:0] upd_rd_tree,
  input  logic [SET_W-1:0]  vic_rd_set,
  output logic [TREE_W-1:0] vic_rd_tree
);
  logic [TREE_W-1:0] trees_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trees_q[s] <= '0;
      end else begin
        unique case (op)
          TREE_CLEAR: trees_q[s] <= '0;
          TREE_WRITE: if (wr_set == SET_W'(s)) trees_q[s] <= wr_tree;
          default:    trees_q[s] <= trees_q[s];
        endcase
      end
    end
  end

  assign upd_rd_tree = trees_q[upd_rd_set];
  assign vic_rd_tree = trees_q[vic_rd_set];
endmodule

// File: rtl/plru_replacer.sv
module plru_replacer
  import plru_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);
  localparam int LEVELS = tree_levels(WAYS);
  localparam int TREE_W = (WAYS > 1) ? WAYS - 1 : 1;

  assign upd_ready = ~clear_all;

  if (WAYS > 1) begin : g_tree
    tree_op_e          op;
    logic [TREE_W-1:0] cur_tree, next_tree, vic_tree;

    always_comb begin
      if (clear_all)      op = TREE_CLEAR;
      else if (upd_valid) op = TREE_WRITE;
      else                op = TREE_HOLD;
    end

    plru_tree_store #(.SETS(SETS), .SET_W(SET_W), .TREE_W(TREE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .op(op),
      .wr_set(upd_set), .wr_tree(next_tree),
      .upd_rd_set(upd_set), .upd_rd_tree(cur_tree),
      .vic_rd_set(vic_set), .vic_rd_tree(vic_tree)
    );

    plru_path_update #(.LEVELS(LEVELS), .WAY_W(WAY_W), .TREE_W(TREE_W)) u_upd (
      .old_tree(cur_tree), .way(upd_way), .new_tree(next_tree)
    );

    plru_victim_walk #(.LEVELS(LEVELS), .WAY_W(WAY_W), .TREE_W(TREE_W)) u_walk (
      .tree(vic_tree), .victim(vic_way)
    );
  end else begin : g_single
    assign vic_way = '0;
  end
endmodule

// File: rtl/plru_replacer_chk.sv
module plru_replacer_chk #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WAY_W = 2,
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_all,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic [SET_W-1:0] upd_set,
  input logic [WAY_W-1:0] upd_way,
  input logic [SET_W-1:0] vic_set,
  input logic [WAY_W-1:0] vic_way
);
  AST_CLEAR_BLOCKS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |-> !upd_ready); // R5

  AST_CLEAR_ZERO_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_all) |-> vic_way == '0); // R5

  AST_IDLE_VICTIM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid && upd_ready) && !$past(clear_all) && $stable(vic_set))
      |-> $stable(vic_way)); // R6

  if (WAYS > 1) begin : g_multi
    AST_MRU_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(upd_valid && upd_ready) && vic_set == $past(upd_set))
        |-> vic_way != $past(upd_way)); // R8
  end else begin : g_one
    AST_SINGLE_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_ready) |=> vic_way == '0); // R7
  end
endmodule

bind plru_replacer plru_replacer_chk #(
  .WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .SET_W(SET_W)
) u_chk (.*);

// File: tb/plru_replacer_test.sv
module plru_replacer_test;
  localparam int WAYS  = 4;
  localparam int SETS  = 8;
  localparam int WAY_W = 2;
  localparam int SET_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_all = 1'b0;
  logic upd_valid = 1'b0;
  logic [SET_W-1:0] upd_set = '0;
  logic [WAY_W-1:0] upd_way = '0;
  logic [SET_W-1:0] vic_set = '0;
  logic upd_ready, ready_one;
  logic [WAY_W-1:0] vic_way;
  logic [0:0] vic_one;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  plru_replacer #(.WAYS(WAYS), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_set(upd_set), .upd_way(upd_way),
    .vic_set(vic_set), .vic_way(vic_way));

  plru_replacer #(.WAYS(1), .SETS(SETS)) uut_one (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .upd_valid(upd_valid),
    .upd_ready(ready_one), .upd_set(upd_set), .upd_way(1'b0),
    .vic_set(vic_set), .vic_way(vic_one));

  // Reference: heap-indexed tree per set
  int model [SETS][WAYS-1];
  int exp_q[$];
  string req_q[$];

  function automatic void model_clear();
    for (int s = 0; s < SETS; s++)
      for (int n = 0; n < WAYS-1; n++) model[s][n] = 0;
  endfunction

  function automatic void model_use(int s, int w);
    int base, idx, par;
    base = (WAYS - 1) / 2;
    idx = base + w / 2;
    model[s][idx] = (w % 2 == 0) ? 1 : 0;
    while (idx > 0) begin
      par = (idx - 1) / 2;
      model[s][par] = idx % 2;
      idx = par;
    end
  endfunction

  function automatic int model_victim(int s);
    int base, idx, v;
    base = (WAYS - 1) / 2;
    idx = 0;
    while (idx < base) idx = (model[s][idx] == 0) ? 2*idx + 1 : 2*idx + 2;
    v = (idx - base) * 2 + model[s][idx];
    return v;
  endfunction

  function automatic void check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // Monitor: samples away from the edge and pops the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) check(req_q.pop_front(), int'(vic_way), exp_q.pop_front());
    end
  end

  task automatic probe(int s, string req);
    @(negedge clk);
    upd_valid = 1'b0; clear_all = 1'b0; vic_set = SET_W'(s);
    exp_q.push_back(model_victim(s)); req_q.push_back(req);
  endtask

  task automatic use_way(int s, int w);
    @(negedge clk);
    clear_all = 1'b0; upd_valid = 1'b1; upd_set = SET_W'(s); upd_way = WAY_W'(w);
    @(posedge clk);
    model_use(s, w);
  endtask

  // R6: probe the same set in the cycle the update is presented: old value
  task automatic use_and_probe(int s, int w, string req);
    @(negedge clk);
    clear_all = 1'b0; upd_valid = 1'b1; upd_set = SET_W'(s); upd_way = WAY_W'(w);
    vic_set = SET_W'(s);
    exp_q.push_back(model_victim(s)); req_q.push_back(req);
    @(posedge clk);
    model_use(s, w);
  endtask

  task automatic clear_with_update(int s, int w);
    @(negedge clk);
    clear_all = 1'b1; upd_valid = 1'b1; upd_set = SET_W'(s); upd_way = WAY_W'(w);
    #1 check("R5 upd_ready during clear", int'(upd_ready), 0);
    @(posedge clk);
    model_clear();
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int s = 0; s < SETS; s++) probe(s, "R1 reset victim");

    // R9 / R2 / R3 canonical 4-way sequence on set 5
    use_way(5, 0); probe(5, "R9 after way0 expect 2"); check("R9 model", model_victim(5), 2);
    use_way(5, 1); probe(5, "R9 after way1 expect 2");
    use_way(5, 2); probe(5, "R9 after way2 expect 0");
    use_way(5, 3); probe(5, "R9 after way3 expect 0");
    use_way(5, 0); use_way(5, 2); probe(5, "R9 tree 011 expect 1");
    use_way(5, 1); probe(5, "R9 tree 101 expect 3");
    use_way(5, 3); probe(5, "R9 tree 000 expect 0");

    // R4: other sets untouched
    probe(2, "R4 unrelated set");
    probe(4, "R4 unrelated set");

    // R6: same-cycle probe sees the old tree, next cycle the new
    use_way(1, 3);
    use_and_probe(1, 2, "R6 same cycle old state");
    probe(1, "R6 next cycle new state");

    // R8 and R2 over several patterns
    for (int w = 0; w < WAYS; w++) begin
      use_way(3, w);
      probe(3, "R8 MRU not victim");
      check("R8 model", int'(model_victim(3) != w), 1);
    end
    use_way(6, 2); use_way(6, 2); use_way(6, 1); probe(6, "R2 repeat pattern");
    use_way(7, 3); use_way(7, 0); probe(7, "R2 mixed pattern");

    // R7 single-way instance
    @(negedge clk); #1 check("R7 single way victim", int'(vic_one), 0);

    // R5 clear beats update
    clear_with_update(5, 1);
    for (int s = 0; s < SETS; s++) probe(s, "R5 after clear");
    check("R7 single way ready", int'(ready_one), 1);
    @(negedge clk); #1 check("R7 single way victim", int'(vic_one), 0);

    @(negedge clk); upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule